// File: doc/BRIEF.md
# DDR2 Power-Up Initialization Sequencer

This block takes a DDR2 SDRAM device from power-on to a usable state without software help. Once reset is released it walks a fixed list of device commands: two no-operation cycles with a long stabilization wait between them, all-bank precharges, programming of the three extended mode registers and the mode register, two auto-refresh cycles, a DLL-reset release and an output-driver calibration enter/exit pair. It then performs one dummy write, presents the refresh interval for loading into the controller's refresh timer, and finally raises a done flag that stays high until the next reset.

The configuration inputs are static while the sequence runs. They give the column and row field codes, the address decode mode (sequential or interleaved), the data-bus-width flag, the base payloads for the mode and extended mode registers, and the refresh interval. From the geometry settings the block also derives the bit position at which the bank selector sits in the system address. With each command it reports the system-address image of the bank value, so the rest of the controller can map mode-register cycles onto ordinary bus addresses. All outputs are registered. None of the interfaces carries a data stream, so there is no valid/ready handshake: commands are single-cycle strobes and the remaining pins are plain control and status.

Top module: `ddr2_pwrup_seq`

## Requirements
- R1: While `rst_n` is low, `cmd_valid`, `rfi_load` and `init_done` are 0, and `cmd_code`, `cmd_bank`, `cmd_addr`, `cmd_sys_off` and `rfi_value` are all zero.
- R2: Command codes are NOP=0, PREA (precharge all)=1, MRS=2, EMRS=3, REF (auto-refresh)=4, WR (dummy write)=5. In every cycle where `cmd_valid` is 0, `cmd_code` is NOP and `cmd_bank`, `cmd_addr` and `cmd_sys_off` are zero.
- R3: The first command appears in the cycle after the first rising clock edge with `rst_n` high. After that, every command is valid for exactly one cycle, in this order: NOP, NOP, PREA, EMRS bank 2, EMRS bank 3, EMRS bank 1, MRS, PREA, REF, REF, MRS, EMRS bank 1, EMRS bank 1, WR. NOP, PREA, REF and WR use bank 0 and address 0, except for PREA's address bit 10.
- R4: Exactly `CLK_MHZ*STAB_US` idle cycles separate the first NOP from the second NOP.
- R5: After a PREA, exactly `T_RP` idle cycles follow. After a REF, exactly `T_RFC` follow. After the second NOP, each MRS, each EMRS and the WR, exactly `T_MRD` follow.
- R6: PREA drives address bit 10 high and every other address bit low.
- R7: The first MRS carries `cfg_mode_word` with bit 8 (DLL reset) forced to 1. The second MRS carries it with bit 8 forced to 0.
- R8: EMRS to banks 2 and 3 carries address 0. For the bank-1 cycles, bits 9:7 (driver calibration field) are set to 000 on the first and last of the three and to 111 on the middle one; the remaining bits come from `cfg_emode_word`.
- R9: `bank_pos` equals `cfg_col_bits + 9`, plus `cfg_row_bits + 11` only when `cfg_interleave` is 0, plus 1 when `cfg_narrow_bus` is 1 or 2 when it is 0.
- R10: `cmd_sys_off` equals `cmd_bank` shifted left by `bank_pos` in the same cycle as each command.
- R11: `rfi_load` pulses for one cycle, `T_MRD` idle cycles after WR, with `rfi_value` equal to `cfg_refresh_interval`; `rfi_value` is zero in every other cycle. One idle cycle later `init_done` rises and stays high, and no further command or load occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; restarts the sequence |
| cfg_col_bits | input | NC_W | Column field code |
| cfg_row_bits | input | NR_W | Row field code |
| cfg_interleave | input | 1 | 1 = interleaved bank decode, 0 = sequential |
| cfg_narrow_bus | input | 1 | 1 = narrow data bus |
| cfg_mode_word | input | ADDR_W | Mode register base payload |
| cfg_emode_word | input | ADDR_W | Extended mode register 1 base payload |
| cfg_refresh_interval | input | RFI_W | Refresh interval to hand over |
| cmd_valid | output | 1 | A sequence command is present this cycle |
| cmd_code | output | 3 | Command code (R2 encoding) |
| cmd_bank | output | BA_W | Bank address bus |
| cmd_addr | output | ADDR_W | Row/mode address bus |
| cmd_sys_off | output | SYS_AW | Bank value placed at its system-address position |
| bank_pos | output | POS_W | Derived system-address bit of the bank LSB |
| rfi_load | output | 1 | Load strobe for the refresh-interval register |
| rfi_value | output | RFI_W | Refresh interval, valid with `rfi_load` |
| init_done | output | 1 | Initialization complete, sticky until reset |

## Verification
The assertions check on every cycle that idle cycles are quiet, that commands last one cycle, that precharge sets bit 10, that extended-mode cycles target a nonzero bank, that `bank_pos` stays in the range its decode mode allows, and that the done flag follows the load strobe and stays high with the command bus silent. The exact order of commands, the payload of each one, the length of each gap (above all the long stabilization wait) and the bank-offset arithmetic are shown only by the bench. It replays the full expected trace cycle by cycle for both decode modes and both bus widths, with different geometry codes and payloads in each run.

// File: rtl/ddr2i_pkg.sv
package ddr2i_pkg;

  typedef enum logic [2:0] {
    CMD_NOP  = 3'd0,
    CMD_PREA = 3'd1,
    CMD_MRS  = 3'd2,
    CMD_EMRS = 3'd3,
    CMD_REF  = 3'd4,
    CMD_WR   = 3'd5
  } ddr_cmd_e;

  typedef enum logic [2:0] {
    GAP_ONE,
    GAP_STAB,
    GAP_RP,
    GAP_MRD,
    GAP_RFC
  } gap_sel_e;

  typedef enum logic [1:0] {
    ST_ISSUE,
    ST_WAIT,
    ST_DONE
  } seq_state_e;

  localparam int STEP_W    = 4;
  localparam int STEP_DONE = 15;

endpackage

// File: rtl/ddr2i_bank_pos.sv
module ddr2i_bank_pos #(
  parameter int NC_W  = 2,
  parameter int NR_W  = 2,
  parameter int POS_W = 5
) (
  input  logic [NC_W-1:0]  col_fld,
  input  logic [NR_W-1:0]  row_fld,
  input  logic             interleave,
  input  logic             narrow,
  output logic [POS_W-1:0] pos
);
  localparam int COL_BASE = 9;
  localparam int ROW_BASE = 11;

  logic [POS_W-1:0] col_term, row_term, bus_term;

  always_comb begin
    col_term = POS_W'(col_fld) + POS_W'(COL_BASE);
    row_term = interleave ? '0 : POS_W'(row_fld) + POS_W'(ROW_BASE);
    bus_term = narrow ? POS_W'(1) : POS_W'(2);
    pos      = col_term + row_term + bus_term;
  end
endmodule

// File: rtl/ddr2i_gap_timer.sv
module ddr2i_gap_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             last
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= load_val;
    end else if (cnt != '0) begin
      cnt <= cnt - CNT_W'(1);
    end
  end

  assign last = (cnt == CNT_W'(1));
endmodule

// File: rtl/ddr2i_step_dec.sv
module ddr2i_step_dec
  import ddr2i_pkg::*;
#(
  parameter int ADDR_W      = 14,
  parameter int BA_W        = 3,
  parameter int DLL_RST_BIT = 8,
  parameter int OCD_LSB     = 7,
  parameter int PREA_BIT    = 10
) (
  input  logic [STEP_W-1:0] step,
  input  logic [ADDR_W-1:0] mode_word,
  input  logic [ADDR_W-1:0] emode_word,
  output logic              valid,
  output ddr_cmd_e          code,
  output logic [BA_W-1:0]   bank,
  output logic [ADDR_W-1:0] addr,
  output logic              rfi,
  output gap_sel_e          gap
);
  localparam logic [ADDR_W-1:0] DLL_MASK  = ADDR_W'(1) << DLL_RST_BIT;
  localparam logic [ADDR_W-1:0] OCD_MASK  = ADDR_W'(7) << OCD_LSB;
  localparam logic [ADDR_W-1:0] PREA_MASK = ADDR_W'(1) << PREA_BIT;

  always_comb begin
    valid = 1'b1;
    code  = CMD_NOP;
    bank  = '0;
    addr  = '0;
    rfi   = 1'b0;
    gap   = GAP_MRD;
    case (step)
      4'd0:  gap = GAP_STAB;
      4'd1:  ;
      4'd2, 4'd7: begin
        code = CMD_PREA;
        addr = PREA_MASK;
        gap  = GAP_RP;
      end
      4'd3: begin code = CMD_EMRS; bank = BA_W'(2); end
      4'd4: begin code = CMD_EMRS; bank = BA_W'(3); end
      4'd5, 4'd12: begin
        code = CMD_EMRS;
        bank = BA_W'(1);
        addr = emode_word & ~OCD_MASK;
      end
      4'd11: begin
        code = CMD_EMRS;
        bank = BA_W'(1);
        addr = emode_word | OCD_MASK;
      end
      4'd6:  begin code = CMD_MRS; addr = mode_word | DLL_MASK; end
      4'd10: begin code = CMD_MRS; addr = mode_word & ~DLL_MASK; end
      4'd8, 4'd9: begin code = CMD_REF; gap = GAP_RFC; end
      4'd13: code = CMD_WR;
      4'd14: begin valid = 1'b0; rfi = 1'b1; gap = GAP_ONE; end
      default: begin valid = 1'b0; gap = GAP_ONE; end
    endcase
  end
endmodule

// File: rtl/ddr2_pwrup_seq.sv
module ddr2_pwrup_seq
  import ddr2i_pkg::*;
#(
  parameter int CLK_MHZ = 400,
  parameter int STAB_US = 200,
  parameter int T_RP    = 4,
  parameter int T_MRD   = 2,
  parameter int T_RFC   = 26,
  parameter int ADDR_W  = 14,
  parameter int BA_W    = 3,
  parameter int NC_W    = 2,
  parameter int NR_W    = 2,
  parameter int RFI_W   = 12,
  parameter int SYS_AW  = 32,
  localparam int POS_MAX = (2**NC_W - 1) + 9 + (2**NR_W - 1) + 11 + 2,
  localparam int POS_W   = $clog2(POS_MAX + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NC_W-1:0]   cfg_col_bits,
  input  logic [NR_W-1:0]   cfg_row_bits,
  input  logic              cfg_interleave,
  input  logic              cfg_narrow_bus,
  input  logic [ADDR_W-1:0] cfg_mode_word,
  input  logic [ADDR_W-1:0] cfg_emode_word,
  input  logic [RFI_W-1:0]  cfg_refresh_interval,
  output logic              cmd_valid,
  output logic [2:0]        cmd_code,
  output logic [BA_W-1:0]   cmd_bank,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic [SYS_AW-1:0] cmd_sys_off,
  output logic [POS_W-1:0]  bank_pos,
  output logic              rfi_load,
  output logic [RFI_W-1:0]  rfi_value,
  output logic              init_done
);
  localparam int STAB_CYC = CLK_MHZ * STAB_US;
  localparam int GAP_MAX1 = (T_RP > T_MRD) ? T_RP : T_MRD;
  localparam int GAP_MAX2 = (GAP_MAX1 > T_RFC) ? GAP_MAX1 : T_RFC;
  localparam int GAP_MAX  = (GAP_MAX2 > STAB_CYC) ? GAP_MAX2 : STAB_CYC;
  localparam int CNT_W    = $clog2(GAP_MAX + 1);

  seq_state_e        state;
  logic [STEP_W-1:0] step;

  logic              dec_valid, dec_rfi;
  ddr_cmd_e          dec_code;
  logic [BA_W-1:0]   dec_bank;
  logic [ADDR_W-1:0] dec_addr;
  gap_sel_e          dec_gap;

  logic              tmr_load, tmr_last;
  logic [CNT_W-1:0]  gap_val;

  ddr2i_bank_pos #(.NC_W(NC_W), .NR_W(NR_W), .POS_W(POS_W)) u_pos (
    .col_fld    (cfg_col_bits),
    .row_fld    (cfg_row_bits),
    .interleave (cfg_interleave),
    .narrow     (cfg_narrow_bus),
    .pos        (bank_pos)
  );

  ddr2i_step_dec #(.ADDR_W(ADDR_W), .BA_W(BA_W)) u_dec (
    .step       (step),
    .mode_word  (cfg_mode_word),
    .emode_word (cfg_emode_word),
    .valid      (dec_valid),
    .code       (dec_code),
    .bank       (dec_bank),
    .addr       (dec_addr),
    .rfi        (dec_rfi),
    .gap        (dec_gap)
  );

  always_comb begin
    case (dec_gap)
      GAP_STAB: gap_val = CNT_W'(STAB_CYC);
      GAP_RP:   gap_val = CNT_W'(T_RP);
      GAP_MRD:  gap_val = CNT_W'(T_MRD);
      GAP_RFC:  gap_val = CNT_W'(T_RFC);
      default:  gap_val = CNT_W'(1);
    endcase
  end

  assign tmr_load = (state == ST_ISSUE) && (step != STEP_W'(STEP_DONE));

  ddr2i_gap_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (gap_val),
    .last     (tmr_last)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= ST_ISSUE;
      step        <= '0;
      cmd_valid   <= 1'b0;
      cmd_code    <= CMD_NOP;
      cmd_bank    <= '0;
      cmd_addr    <= '0;
      cmd_sys_off <= '0;
      rfi_load    <= 1'b0;
      rfi_value   <= '0;
      init_done   <= 1'b0;
    end else begin
      cmd_valid   <= 1'b0;
      cmd_code    <= CMD_NOP;
      cmd_bank    <= '0;
      cmd_addr    <= '0;
      cmd_sys_off <= '0;
      rfi_load    <= 1'b0;
      rfi_value   <= '0;
      case (state)
        ST_ISSUE: begin
          if (step == STEP_W'(STEP_DONE)) begin
            init_done <= 1'b1;
            state     <= ST_DONE;
          end else begin
            cmd_valid   <= dec_valid;
            cmd_code    <= dec_code;
            cmd_bank    <= dec_bank;
            cmd_addr    <= dec_addr;
            cmd_sys_off <= SYS_AW'(dec_bank) << bank_pos;
            rfi_load    <= dec_rfi;
            rfi_value   <= dec_rfi ? cfg_refresh_interval : '0;
            step        <= step + STEP_W'(1);
            state       <= ST_WAIT;
          end
        end
        ST_WAIT: if (tmr_last) state <= ST_ISSUE;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/ddr2_pwrup_seq_chk.sv
module ddr2_pwrup_seq_chk #(
  parameter int ADDR_W = 14,
  parameter int BA_W   = 3,
  parameter int NC_W   = 2,
  parameter int POS_W  = 5,
  parameter int SYS_AW = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_interleave,
  input logic              cmd_valid,
  input logic [2:0]        cmd_code,
  input logic [BA_W-1:0]   cmd_bank,
  input logic [ADDR_W-1:0] cmd_addr,
  input logic [SYS_AW-1:0] cmd_sys_off,
  input logic [POS_W-1:0]  bank_pos,
  input logic              rfi_load,
  input logic              init_done
);
  localparam int ILV_MAX = (2**NC_W - 1) + 9 + 2;
  localparam int SEQ_MIN = 9 + 11 + 1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      AST_RESET_QUIET: assert (!cmd_valid && !rfi_load && !init_done); // R1
    end
  end

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_valid |-> (cmd_code == 3'd0 && cmd_bank == '0 && cmd_addr == '0 && cmd_sys_off == '0)); // R2

  AST_ONE_CYCLE_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> !cmd_valid); // R5

  AST_PREA_ALL_BANKS: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_code == 3'd1) |-> cmd_addr[10]); // R6

  AST_EMRS_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_code == 3'd3) |-> (cmd_bank != '0 && cmd_bank <= BA_W'(3))); // R8

  AST_POS_INTERLEAVED: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_interleave |-> (int'(bank_pos) <= ILV_MAX)); // R9

  AST_POS_SEQUENTIAL: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_interleave |-> (int'(bank_pos) >= SEQ_MIN)); // R9

  AST_LOAD_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rfi_load |=> !rfi_load); // R11

  AST_DONE_AFTER_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(init_done) |-> $past(rfi_load, 2)); // R11

  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |=> init_done); // R11

  AST_SILENT_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |-> (!cmd_valid && !rfi_load)); // R11
endmodule

bind ddr2_pwrup_seq ddr2_pwrup_seq_chk #(
  .ADDR_W(ADDR_W), .BA_W(BA_W), .NC_W(NC_W), .POS_W(POS_W), .SYS_AW(SYS_AW)
) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .cfg_interleave (cfg_interleave),
  .cmd_valid      (cmd_valid),
  .cmd_code       (cmd_code),
  .cmd_bank       (cmd_bank),
  .cmd_addr       (cmd_addr),
  .cmd_sys_off    (cmd_sys_off),
  .bank_pos       (bank_pos),
  .rfi_load       (rfi_load),
  .init_done      (init_done)
);

// File: tb/ddr2_pwrup_seq_bench.sv
module ddr2_pwrup_seq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int MHZ   = 1;
  localparam int STAB  = 200;
  localparam int TRP   = 2;
  localparam int TMRD  = 3;
  localparam int TRFC  = 5;
  localparam int AW    = 14;
  localparam int BW    = 3;
  localparam int RW    = 12;
  localparam int PW    = 5;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [1:0]    col = '0, row = '0;
  logic          ilv = 1'b0, nar = 1'b0;
  logic [AW-1:0] mword = '0, eword = '0;
  logic [RW-1:0] rfi = '0;

  logic          cmd_valid, rfi_load, init_done;
  logic [2:0]    cmd_code;
  logic [BW-1:0] cmd_bank;
  logic [AW-1:0] cmd_addr;
  logic [31:0]   cmd_sys_off;
  logic [PW-1:0] bank_pos;
  logic [RW-1:0] rfi_value;

  int n_cmp = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ddr2_pwrup_seq #(
    .CLK_MHZ(MHZ), .STAB_US(STAB), .T_RP(TRP), .T_MRD(TMRD), .T_RFC(TRFC),
    .ADDR_W(AW), .BA_W(BW), .RFI_W(RW)
  ) u_ddr2_pwrup_seq (
    .clk(clk), .rst_n(rst_n),
    .cfg_col_bits(col), .cfg_row_bits(row),
    .cfg_interleave(ilv), .cfg_narrow_bus(nar),
    .cfg_mode_word(mword), .cfg_emode_word(eword),
    .cfg_refresh_interval(rfi),
    .cmd_valid(cmd_valid), .cmd_code(cmd_code), .cmd_bank(cmd_bank),
    .cmd_addr(cmd_addr), .cmd_sys_off(cmd_sys_off), .bank_pos(bank_pos),
    .rfi_load(rfi_load), .rfi_value(rfi_value), .init_done(init_done)
  );

  typedef struct {
    bit            v;
    logic [2:0]    c;
    logic [BW-1:0] b;
    logic [AW-1:0] a;
    bit            rl;
    bit            dn;
    string         tag;
  } ent_t;

  ent_t q[$];

  task automatic push(bit v, logic [2:0] c, logic [BW-1:0] b, logic [AW-1:0] a,
                      bit rl, bit dn, string tag);
    ent_t e;
    e.v = v; e.c = c; e.b = b; e.a = a; e.rl = rl; e.dn = dn; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic add_cmd(logic [2:0] c, logic [BW-1:0] b, logic [AW-1:0] a,
                         int gap, string tag, string gtag);
    push(1'b1, c, b, a, 1'b0, 1'b0, tag);
    for (int i = 0; i < gap; i++) push(1'b0, 3'd0, '0, '0, 1'b0, 1'b0, gtag);
  endtask

  function automatic int exp_pos();
    int p;
    p = int'(col) + 9;
    if (!ilv) p += int'(row) + 11;
    p += nar ? 1 : 2;
    return p;
  endfunction

  task automatic check(bit ok, string tag, string what, logic [63:0] act, logic [63:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic run(logic [1:0] c_, logic [1:0] r_, bit i_, bit n_,
                     logic [AW-1:0] m_, logic [AW-1:0] e_, logic [RW-1:0] f_);
    logic [AW-1:0] dll, ocd, prea;
    int pos;
    @(negedge clk);
    rst_n = 1'b0;
    col = c_; row = r_; ilv = i_; nar = n_; mword = m_; eword = e_; rfi = f_;
    repeat (3) @(negedge clk);
    check(!cmd_valid && cmd_code == 3'd0 && cmd_bank == '0 && cmd_addr == '0 &&
          cmd_sys_off == '0 && !rfi_load && rfi_value == '0 && !init_done,
          "R1", "reset outputs",
          {cmd_valid, cmd_code, cmd_addr, rfi_load, init_done}, 64'h0);
    pos = exp_pos();
    check(int'(bank_pos) == pos, "R9", "bank_pos", 64'(bank_pos), 64'(pos));

    dll  = AW'(1) << 8;
    ocd  = AW'(7) << 7;
    prea = AW'(1) << 10;
    q.delete();
    add_cmd(3'd0, 0, '0, MHZ*STAB, "R3", "R4");                // NOP then stabilization
    add_cmd(3'd0, 0, '0, TMRD, "R4", "R5");
    add_cmd(3'd1, 0, prea, TRP, "R6", "R5");
    add_cmd(3'd3, 2, '0, TMRD, "R8", "R5");
    add_cmd(3'd3, 3, '0, TMRD, "R8", "R5");
    add_cmd(3'd3, 1, e_ & ~ocd, TMRD, "R8", "R5");
    add_cmd(3'd2, 0, m_ | dll, TMRD, "R7", "R5");
    add_cmd(3'd1, 0, prea, TRP, "R6", "R5");
    add_cmd(3'd4, 0, '0, TRFC, "R3", "R5");
    add_cmd(3'd4, 0, '0, TRFC, "R3", "R5");
    add_cmd(3'd2, 0, m_ & ~dll, TMRD, "R7", "R5");
    add_cmd(3'd3, 1, e_ | ocd, TMRD, "R8", "R5");
    add_cmd(3'd3, 1, e_ & ~ocd, TMRD, "R8", "R5");
    add_cmd(3'd5, 0, '0, TMRD, "R3", "R11");
    push(1'b0, 3'd0, '0, '0, 1'b1, 1'b0, "R11");
    push(1'b0, 3'd0, '0, '0, 1'b0, 1'b0, "R2");
    for (int k = 0; k < 6; k++) push(1'b0, 3'd0, '0, '0, 1'b0, 1'b1, "R11");

    rst_n = 1'b1;
    while (q.size() > 0) begin
      ent_t e;
      logic [31:0] xoff;
      e = q.pop_front();
      @(posedge clk);
      @(negedge clk);
      check(cmd_valid == e.v && cmd_code == e.c && cmd_bank == e.b && cmd_addr == e.a &&
            rfi_load == e.rl && init_done == e.dn, e.tag, "cmd trace",
            {cmd_valid, cmd_code, cmd_bank, cmd_addr, rfi_load, init_done},
            {e.v, e.c, e.b, e.a, e.rl, e.dn});
      xoff = 32'(e.b) << pos;
      check(cmd_sys_off == xoff, "R10", "sys offset", 64'(cmd_sys_off), 64'(xoff));
      check(rfi_value == (e.rl ? f_ : '0), "R11", "rfi value", 64'(rfi_value),
            64'(e.rl ? f_ : '0));
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL R3 watchdog: cycles=100000 expected=sequence end");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    // sequential decode, wide bus; mode word bit 8 clear
    run(2'd2, 2'd1, 1'b0, 1'b0, 14'h0A53, 14'h0044, 12'h3C5);
    // sequential decode, narrow bus; mode bit 8 set, calibration bits set in base
    run(2'd3, 2'd3, 1'b0, 1'b1, 14'h1D2F, 14'h03C6, 12'hFFF);
    // interleaved decode, wide bus
    run(2'd0, 2'd2, 1'b1, 1'b0, 14'h0000, 14'h3FFF, 12'h001);
    // interleaved decode, narrow bus
    run(2'd1, 2'd0, 1'b1, 1'b1, 14'h3FFF, 14'h0000, 12'h800);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule